// File: doc/BRIEF.md
# Secure Mode and Region Access Guard

This block keeps the processor's security mode and judges every memory access against a set of address regions. A program starts in an open, untrusted mode. An enter command first requests a measurement (hash) of the code about to be secured, handled outside this block. The mode moves into one of two secure modes only when that measurement reports done. A secure program may pause into a suspended mode. That mode runs in the same process but loses every right to the protected regions. The program may leave the suspended mode only through a resume that names the exact program counter recorded at the pause.

Four base/limit pairs carve out the protected regions: read-only checked, read-only checked and sealed (encrypted), writable checked, and writable checked and sealed. Every address outside them is plain memory. For each access the block returns, one cycle later, the region it fell in, a fault flag, and two flags for the memory path: run integrity checking, and run encryption.

States of the mode machine and their codes on `sec_mode`: OPEN (0, untrusted), MEASURE (1, waiting for the hash), VERIFIED (2, integrity only), PRIVATE (3, integrity and privacy), PAUSED (4, suspended). Transitions: OPEN→MEASURE on enter; MEASURE→VERIFIED or MEASURE→PRIVATE on hash done, chosen by the level the enter asked for; VERIFIED→PAUSED and PRIVATE→PAUSED on suspend; PAUSED→VERIFIED or PAUSED→PRIVATE (back to the mode that was suspended) on a resume with the matching address. Reset returns to OPEN.

Top module: `secure_access_guard`

## Requirements
- R1: After reset `sec_mode` is 0 (OPEN), `hash_req`, `cmd_fault` and `rsp_valid` are 0.
- R2: Command codes on `cmd_op` are 0 none, 1 enter, 2 suspend, 3 resume. An enter in OPEN moves to MEASURE (code 1), where `hash_req` is 1. A `hash_done` pulse in MEASURE moves to VERIFIED (2) if the enter carried `cmd_priv`=0, or PRIVATE (3) if it carried 1. `hash_done` in any other state has no effect.
- R3: A suspend in VERIFIED or PRIVATE moves to PAUSED (4) and records `cmd_pc` as the resume point. Each suspend replaces the earlier one.
- R4: A resume in PAUSED whose `cmd_pc` equals the recorded resume point returns to the secure mode that was suspended. Any other resume address raises `cmd_fault` and leaves the mode at PAUSED.
- R5: Any command other than none that is not listed in R2 to R4 for the current state raises `cmd_fault` and leaves the mode unchanged. `cmd_fault` and a mode change appear one cycle after the command.
- R6: Region codes on `rsp_region`: 0 read-only checked, 1 read-only sealed, 2 writable checked, 3 writable sealed, 4 plain. Pair i (i = code) covers base_i ≤ addr ≤ limit_i. The lowest matching index wins, and an address matching none is plain. The response appears with `rsp_valid` one cycle after `acc_valid` and uses the mode of the request cycle.
- R7: A write to region 0 or 1 faults in every mode.
- R8: Any access to regions 0 to 3 faults in OPEN, MEASURE and PAUSED.
- R9: An access to region 1 or 3 in VERIFIED faults.
- R10: An allowed access to regions 0 to 3 sets `rsp_verify`, and one to regions 1 or 3 also sets `rsp_encrypt`. A faulting access or one to plain memory sets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Mode command present |
| cmd_op | input | 2 | Command code (R2) |
| cmd_priv | input | 1 | Enter level: 0 integrity only, 1 private |
| cmd_pc | input | PCW | Resume point on suspend, target on resume |
| hash_done | input | 1 | Code measurement finished |
| hash_req | output | 1 | Measurement requested (in MEASURE) |
| sec_mode | output | 3 | Current mode code |
| cmd_fault | output | 1 | Previous command rejected |
| rgn_base | input | 4*AW | Base address of each protected region, region i at bits i*AW |
| rgn_limit | input | 4*AW | Inclusive limit of each protected region |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | AW | Access address |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_fault | output | 1 | Access denied |
| rsp_verify | output | 1 | Memory path must check integrity |
| rsp_encrypt | output | 1 | Memory path must encrypt/decrypt |
| rsp_region | output | 3 | Region code of the access |

## Verification
The properties assume that `hash_done` is a pulse raised only while the measurement runs, and that the region bounds are held steady across an access and its response. A response is related to the previous cycle's write flag and mode, so the bounds must not move in between. The stimulus changes bounds only between accesses, pulses `hash_done` only in MEASURE except for one deliberate stray pulse in OPEN, and drives commands and accesses one per cycle on the falling edge. Random addresses are drawn only while the bounds stay fixed.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [2:0] {
        MODE_OPEN     = 3'd0,
        MODE_MEASURE  = 3'd1,
        MODE_VERIFIED = 3'd2,
        MODE_PRIVATE  = 3'd3,
        MODE_PAUSED   = 3'd4
    } sec_mode_e;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_ENTER   = 2'd1,
        OP_SUSPEND = 2'd2,
        OP_RESUME  = 2'd3
    } cmd_op_e;

    typedef enum logic [2:0] {
        RGN_RO_CHK  = 3'd0,
        RGN_RO_SEAL = 3'd1,
        RGN_RW_CHK  = 3'd2,
        RGN_RW_SEAL = 3'd3,
        RGN_PLAIN   = 3'd4
    } rgn_kind_e;

    localparam int NUM_PROT = 4;

    function automatic logic kind_is_static(rgn_kind_e k);
        return (k == RGN_RO_CHK) || (k == RGN_RO_SEAL);
    endfunction

    function automatic logic kind_is_sealed(rgn_kind_e k);
        return (k == RGN_RO_SEAL) || (k == RGN_RW_SEAL);
    endfunction

    function automatic logic kind_is_protected(rgn_kind_e k);
        return k != RGN_PLAIN;
    endfunction

endpackage

// File: rtl/sag_mode_fsm.sv
module sag_mode_fsm
    import sag_pkg::*;
#(
    parameter int PCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic           cmd_priv,
    input  logic [PCW-1:0] cmd_pc,
    input  logic           hash_done,
    output sec_mode_e      mode,
    output logic           hash_req,
    output logic           cmd_fault
);

    sec_mode_e      state_q, state_d;
    logic           want_priv_q, want_priv_d;
    logic           saved_priv_q, saved_priv_d;
    logic [PCW-1:0] resume_pc_q, resume_pc_d;
    logic           fault_q, fault_d;
    cmd_op_e        op;
    logic           any_cmd;

    assign op      = cmd_op_e'(cmd_op);
    assign any_cmd = cmd_valid && (op != OP_NONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= MODE_OPEN;
            want_priv_q  <= 1'b0;
            saved_priv_q <= 1'b0;
            resume_pc_q  <= '0;
            fault_q      <= 1'b0;
        end else begin
            state_q      <= state_d;
            want_priv_q  <= want_priv_d;
            saved_priv_q <= saved_priv_d;
            resume_pc_q  <= resume_pc_d;
            fault_q      <= fault_d;
        end
    end

    // next state
    always_comb begin
        state_d      = state_q;
        want_priv_d  = want_priv_q;
        saved_priv_d = saved_priv_q;
        resume_pc_d  = resume_pc_q;
        fault_d      = 1'b0;
        unique case (state_q)
            MODE_OPEN: begin
                if (any_cmd) begin
                    if (op == OP_ENTER) begin
                        state_d     = MODE_MEASURE;
                        want_priv_d = cmd_priv;
                    end else begin
                        fault_d = 1'b1;
                    end
                end
            end
            MODE_MEASURE: begin
                if (hash_done) begin
                    state_d = want_priv_q ? MODE_PRIVATE : MODE_VERIFIED;
                end
                if (any_cmd) begin
                    fault_d = 1'b1;
                end
            end
            MODE_VERIFIED, MODE_PRIVATE: begin
                if (any_cmd) begin
                    if (op == OP_SUSPEND) begin
                        state_d      = MODE_PAUSED;
                        resume_pc_d  = cmd_pc;
                        saved_priv_d = (state_q == MODE_PRIVATE);
                    end else begin
                        fault_d = 1'b1;
                    end
                end
            end
            MODE_PAUSED: begin
                if (any_cmd) begin
                    if ((op == OP_RESUME) && (cmd_pc == resume_pc_q)) begin
                        state_d = saved_priv_q ? MODE_PRIVATE : MODE_VERIFIED;
                    end else begin
                        fault_d = 1'b1;
                    end
                end
            end
            default: begin
                state_d = MODE_OPEN;
            end
        endcase
    end

    // outputs
    always_comb begin
        mode      = state_q;
        hash_req  = (state_q == MODE_MEASURE);
        cmd_fault = fault_q;
    end

endmodule

// File: rtl/sag_region_decode.sv
module sag_region_decode
    import sag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]          addr,
    input  logic [NUM_PROT*AW-1:0] base_flat,
    input  logic [NUM_PROT*AW-1:0] limit_flat,
    output rgn_kind_e              kind
);

    logic [NUM_PROT-1:0] hit;

    for (genvar i = 0; i < NUM_PROT; i++) begin : g_cmp
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
        assign lo     = base_flat[i*AW +: AW];
        assign hi     = limit_flat[i*AW +: AW];
        assign hit[i] = (addr >= lo) && (addr <= hi);
    end

    // lowest index has priority
    always_comb begin
        kind = RGN_PLAIN;
        for (int i = NUM_PROT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                kind = rgn_kind_e'(3'(i));
            end
        end
    end

endmodule

// File: rtl/sag_access_check.sv
module sag_access_check
    import sag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  rgn_kind_e  kind,
    input  sec_mode_e  mode,
    output logic       rsp_valid,
    output logic       rsp_fault,
    output logic       rsp_verify,
    output logic       rsp_encrypt,
    output rgn_kind_e  rsp_region
);

    logic deny_static;
    logic deny_untrusted;
    logic deny_private;
    logic deny;

    always_comb begin
        deny_static    = acc_write && kind_is_static(kind);
        deny_untrusted = kind_is_protected(kind) &&
                         ((mode == MODE_OPEN) || (mode == MODE_MEASURE) ||
                          (mode == MODE_PAUSED));
        deny_private   = kind_is_sealed(kind) && (mode == MODE_VERIFIED);
        deny           = deny_static || deny_untrusted || deny_private;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_verify  <= 1'b0;
            rsp_encrypt <= 1'b0;
            rsp_region  <= RGN_PLAIN;
        end else begin
            rsp_valid <= acc_valid;
            if (acc_valid) begin
                rsp_fault   <= deny;
                rsp_verify  <= !deny && kind_is_protected(kind);
                rsp_encrypt <= !deny && kind_is_sealed(kind);
                rsp_region  <= kind;
            end else begin
                rsp_fault   <= 1'b0;
                rsp_verify  <= 1'b0;
                rsp_encrypt <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/secure_access_guard.sv
module secure_access_guard
    import sag_pkg::*;
#(
    parameter int AW  = 16,
    parameter int PCW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic                   cmd_priv,
    input  logic [PCW-1:0]         cmd_pc,
    input  logic                   hash_done,
    output logic                   hash_req,
    output logic [2:0]             sec_mode,
    output logic                   cmd_fault,
    input  logic [NUM_PROT*AW-1:0] rgn_base,
    input  logic [NUM_PROT*AW-1:0] rgn_limit,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [AW-1:0]          acc_addr,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic                   rsp_verify,
    output logic                   rsp_encrypt,
    output logic [2:0]             rsp_region
);

    sec_mode_e mode;
    rgn_kind_e kind;
    rgn_kind_e rsp_kind;

    sag_mode_fsm #(.PCW(PCW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_priv  (cmd_priv),
        .cmd_pc    (cmd_pc),
        .hash_done (hash_done),
        .mode      (mode),
        .hash_req  (hash_req),
        .cmd_fault (cmd_fault)
    );

    sag_region_decode #(.AW(AW)) i_dec (
        .addr       (acc_addr),
        .base_flat  (rgn_base),
        .limit_flat (rgn_limit),
        .kind       (kind)
    );

    sag_access_check i_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .kind        (kind),
        .mode        (mode),
        .rsp_valid   (rsp_valid),
        .rsp_fault   (rsp_fault),
        .rsp_verify  (rsp_verify),
        .rsp_encrypt (rsp_encrypt),
        .rsp_region  (rsp_kind)
    );

    assign sec_mode   = mode;
    assign rsp_region = rsp_kind;

endmodule

// File: rtl/secure_access_guard_chk.sv
module secure_access_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hash_done,
    input logic       acc_write,
    input logic [2:0] sec_mode,
    input logic       cmd_fault,
    input logic       rsp_valid,
    input logic       rsp_fault,
    input logic       rsp_verify,
    input logic       rsp_encrypt,
    input logic [2:0] rsp_region
);

    assert_std_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_mode) == 3'd0) |-> (sec_mode == 3'd0 || sec_mode == 3'd1));

    assert_hash_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_mode) == 3'd1 && sec_mode != 3'd1) |-> $past(hash_done));

    assert_resume_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_mode) == 3'd4 && sec_mode != 3'd4) |-> (sec_mode == 3'd2 || sec_mode == 3'd3));

    assert_fault_nochange_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fault |-> $stable(sec_mode));

    assert_static_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region < 3'd2 && $past(acc_write)) |-> rsp_fault);

    assert_untrusted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region != 3'd4 &&
         ($past(sec_mode) == 3'd0 || $past(sec_mode) == 3'd1 || $past(sec_mode) == 3'd4))
        |-> rsp_fault);

    assert_private_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(sec_mode) == 3'd2 && (rsp_region == 3'd1 || rsp_region == 3'd3))
        |-> rsp_fault);

    assert_flags_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!rsp_verify && !rsp_encrypt));

    assert_encrypt_verify_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_encrypt |-> rsp_verify);

endmodule

bind secure_access_guard secure_access_guard_chk i_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hash_done   (hash_done),
    .acc_write   (acc_write),
    .sec_mode    (sec_mode),
    .cmd_fault   (cmd_fault),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_verify  (rsp_verify),
    .rsp_encrypt (rsp_encrypt),
    .rsp_region  (rsp_region)
);

// File: tb/test_secure_access_guard.sv
`timescale 1ns/1ps
module test_secure_access_guard;

    localparam int AW  = 16;
    localparam int PCW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = 2'd0;
    logic           cmd_priv = 1'b0;
    logic [PCW-1:0] cmd_pc = '0;
    logic           hash_done = 1'b0;
    logic           hash_req;
    logic [2:0]     sec_mode;
    logic           cmd_fault;
    logic [AW-1:0]  bb [4];
    logic [AW-1:0]  bl [4];
    logic [4*AW-1:0] rgn_base, rgn_limit;
    logic           acc_valid = 1'b0;
    logic           acc_write = 1'b0;
    logic [AW-1:0]  acc_addr = '0;
    logic           rsp_valid, rsp_fault, rsp_verify, rsp_encrypt;
    logic [2:0]     rsp_region;

    int checks = 0;
    int errors = 0;
    int seed_tmp;

    assign rgn_base  = {bb[3], bb[2], bb[1], bb[0]};
    assign rgn_limit = {bl[3], bl[2], bl[1], bl[0]};

    always #2 clk = ~clk;

    secure_access_guard #(.AW(AW), .PCW(PCW)) i_secure_access_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_priv(cmd_priv), .cmd_pc(cmd_pc), .hash_done(hash_done),
        .hash_req(hash_req), .sec_mode(sec_mode), .cmd_fault(cmd_fault),
        .rgn_base(rgn_base), .rgn_limit(rgn_limit), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_verify(rsp_verify),
        .rsp_encrypt(rsp_encrypt), .rsp_region(rsp_region)
    );

    function automatic int exp_kind(logic [AW-1:0] a);
        for (int i = 0; i < 4; i++)
            if (a >= bb[i] && a <= bl[i]) return i;
        return 4;
    endfunction

    function automatic logic exp_fault(int m, int k, logic wr);
        if (k < 2 && wr) return 1'b1;
        if (k == 4) return 1'b0;
        if (m == 0 || m == 1 || m == 4) return 1'b1;
        if (m == 2 && (k == 1 || k == 3)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string why(int m, int k, logic wr);
        if (k < 2 && wr) return "R7";
        if (k != 4 && (m == 0 || m == 1 || m == 4)) return "R8";
        if (m == 2 && (k == 1 || k == 3)) return "R9";
        return "R10";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 0; acc_valid = 0; hash_done = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_cmd(int op, logic pv, logic [PCW-1:0] pc, int exp_m, logic exp_f, string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_priv = pv; cmd_pc = pc;
        @(posedge clk); #1;
        check({tag, " mode"}, int'(sec_mode), exp_m);
        check({tag, " cmd_fault"}, int'(cmd_fault), int'(exp_f));
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_done(int exp_m, string tag);
        @(negedge clk);
        hash_done = 1'b1;
        @(posedge clk); #1;
        check({tag, " mode after hash_done"}, int'(sec_mode), exp_m);
        @(negedge clk);
        hash_done = 1'b0;
    endtask

    task automatic do_acc(logic [AW-1:0] a, logic wr);
        int m, k;
        logic f;
        string t;
        @(negedge clk);
        m = int'(sec_mode);
        k = exp_kind(a);
        f = exp_fault(m, k, wr);
        t = why(m, k, wr);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        @(posedge clk); #1;
        check("R6 rsp_valid", int'(rsp_valid), 1);
        check("R6 region", int'(rsp_region), k);
        check({t, " fault"}, int'(rsp_fault), int'(f));
        check("R10 verify", int'(rsp_verify), int'(!f && k != 4));
        check("R10 encrypt", int'(rsp_encrypt), int'(!f && (k == 1 || k == 3)));
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // directed sweep of every region at both bounds, read and write
    task automatic sweep();
        for (int k = 0; k < 5; k++) begin
            for (int w = 0; w < 2; w++) begin
                if (k < 4) begin
                    do_acc(bb[k], w[0]);
                    do_acc(bl[k], w[0]);
                end else begin
                    do_acc(16'h8000, w[0]);
                    do_acc(16'h0FFF, w[0]);
                end
            end
        end
    endtask

    task automatic rand_acc(int n);
        for (int i = 0; i < n; i++)
            do_acc(16'($urandom_range(0, 16'h5FFF)), 1'($urandom));
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        seed_tmp = $urandom(32'h5EED);
        bb[0] = 16'h1000; bl[0] = 16'h1FFF;
        bb[1] = 16'h2000; bl[1] = 16'h2FFF;
        bb[2] = 16'h3000; bl[2] = 16'h3FFF;
        bb[3] = 16'h4000; bl[3] = 16'h4FFF;
        do_reset();
        check("R1 mode", int'(sec_mode), 0);
        check("R1 hash_req", int'(hash_req), 0);
        check("R1 cmd_fault", int'(cmd_fault), 0);
        check("R1 rsp_valid", int'(rsp_valid), 0);

        // OPEN
        sweep(); rand_acc(20);
        do_cmd(2, 0, 16'h0, 0, 1, "R5 suspend in open");
        do_cmd(3, 0, 16'h0, 0, 1, "R5 resume in open");
        do_cmd(0, 0, 16'h0, 0, 0, "R5 none in open");
        pulse_done(0, "R2 stray");

        // MEASURE
        do_cmd(1, 0, 16'h0, 1, 0, "R2 enter");
        check("R2 hash_req", int'(hash_req), 1);
        do_cmd(2, 0, 16'h0, 1, 1, "R5 suspend in measure");
        sweep();
        pulse_done(2, "R2 to verified");
        check("R2 hash_req cleared", int'(hash_req), 0);

        // VERIFIED
        sweep(); rand_acc(20);
        do_cmd(1, 0, 16'h0, 2, 1, "R5 enter in verified");
        do_cmd(3, 0, 16'h0ABC, 2, 1, "R5 resume in verified");
        do_cmd(2, 0, 16'h0ABC, 4, 0, "R3 suspend");

        // PAUSED
        sweep(); rand_acc(20);
        do_cmd(3, 0, 16'h0ABD, 4, 1, "R4 wrong resume");
        do_cmd(1, 0, 16'h0ABC, 4, 1, "R5 enter in paused");
        do_cmd(3, 0, 16'h0ABC, 2, 0, "R4 resume to verified");

        // PRIVATE
        do_reset();
        check("R1 mode after second reset", int'(sec_mode), 0);
        do_cmd(1, 1, 16'h0, 1, 0, "R2 enter private");
        pulse_done(3, "R2 to private");
        sweep(); rand_acc(20);
        do_cmd(2, 0, 16'h1234, 4, 0, "R3 suspend private");
        do_cmd(3, 0, 16'h0ABC, 4, 1, "R4 stale resume");
        do_cmd(3, 0, 16'h1234, 3, 0, "R4 resume to private");
        do_cmd(2, 0, 16'h0055, 4, 0, "R3 second suspend");
        do_cmd(3, 0, 16'h1234, 4, 1, "R3 old point replaced");
        do_cmd(3, 0, 16'h0055, 3, 0, "R3 new point accepted");

        // R6 overlap priority and bounds
        @(negedge clk);
        bb[2] = 16'h1800; bl[2] = 16'h3FFF;
        do_acc(16'h1900, 1'b0);
        do_acc(16'h2900, 1'b0);
        do_acc(16'h3500, 1'b1);
        do_acc(16'h5000, 1'b1);
        do_acc(16'h0FFF, 1'b0);
        rand_acc(30);

        // R6 idle cycle gives no response
        @(negedge clk);
        acc_valid = 1'b0;
        @(posedge clk); #1;
        check("R6 idle rsp_valid", int'(rsp_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule